// File: doc/BRIEF.md
# Two-Wire Configuration Memory Slave

This block is a slave on a two-wire serial bus: a clock line and an open-drain data line. An external programmer uses it to write and read a small configuration memory inside the chip. The memory is a register array. The block samples both bus lines with the system clock and synchronizes them. It finds start and stop conditions in the sampled lines, then moves through each transaction byte by byte.

A transaction opens with a device byte. That byte carries a fixed 7-bit identity and a direction flag. For a write, two pointer bytes follow, sent most significant bit first. After them come data bytes, which travel least significant bit first. For a read, the slave streams data bytes from the current pointer, also least significant bit first, until the master refuses one. The pointer advances after every data byte in either direction. It keeps its value between transactions. A random read is therefore a write transaction carrying only the pointer bytes, then a repeated start with a read device byte.

The bus is the only data path, so the block has no valid/ready handshake at its edge. Flow control is the acknowledge bit alone. The master paces every bit with the clock, and the slave never holds the clock low. The slave accepts every byte addressed to it. A master that wants no more read data refuses the last byte. Chip-enable selection, multi-master arbitration and nonvolatile write timing are not part of this block.

Top module: `cfgslv_top`

## Requirements
- R1: A falling data line while the clock line is high is a start condition. It restarts byte reception with a device byte from any state, even in the middle of a byte, and no partial byte is stored. A rising data line while the clock is high is a stop condition. It ends the transaction, and the slave releases the data line.
- R2: The device byte is shifted in most significant bit first. Its upper seven bits must equal the DEV_ID parameter (default 7'h53, bit pattern 1010011). Its bit 0 is the direction: 1 is a read, 0 is a write. On a match, the slave pulls the data line low during the ninth clock.
- R3: If the device byte does not match, the slave does not pull the line low in the ninth clock. It gives no acknowledge and writes no memory for any later byte until the next start.
- R4: After a write device byte, two pointer bytes follow, first the high byte and then the low byte. Each is shifted most significant bit first and each is acknowledged. The pointer becomes the low MEM_AW bits of {high, low}.
- R5: Each later byte in a write transaction is shifted least significant bit first, so the first bit on the wire is bit 0. The byte is stored at the pointer and acknowledged. The pointer then increases by one, modulo 2^MEM_AW.
- R6: After acknowledging a read device byte, the slave sends the byte at the pointer as 8 bits, least significant bit first. It pulls the line low for a 0 bit and releases it for a 1 bit.
- R7: In the ninth clock of a read byte, the slave releases the line. A low level from the master (acknowledge) advances the pointer, and the slave sends the next byte. A high level (refusal) also advances the pointer, but the slave stays released and silent until the next start.
- R8: The slave changes its drive on the data line only after a falling edge of the clock line, or on a start or stop. It therefore never changes the line while the clock is high.
- R9: The pointer keeps its value across stop and start. A read that follows a stop, or a repeated start, begins at the byte the pointer names.
- R10: After reset, the data line is released, the pointer is 0 and every memory byte is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level, as seen on the wire |
| sda_pull_o | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
The bench targets the mixed bit ordering. It writes two bytes and then reads back the second by pointer value 0x01. If the pointer bytes were shifted in least significant bit first, the pointer would decode to 0 and the first byte would come back. If the read data went out in the wrong order, the value would arrive bit-reversed. Further corner cases are:
- a device byte that differs from the identity in one bit, followed by bytes that must neither be acknowledged nor stored;
- a start condition in the middle of a data byte, which must not leave a partial write;
- a pointer that wraps from the last location to 0;
- a refused read byte, after which a slave that kept driving would hold the line low and block the master's stop.

// File: rtl/cfgslv_pkg.sv
package cfgslv_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RX,
    PH_ACK_PEND,
    PH_ACK,
    PH_TX,
    PH_MACK,
    PH_TXNEXT
  } phase_t;

  typedef enum logic [1:0] {
    K_DEV,
    K_AHI,
    K_ALO,
    K_DATA
  } kind_t;

  // Byte that follows a given byte inside a write transaction
  function automatic kind_t kind_after(kind_t k);
    case (k)
      K_DEV:   return K_AHI;
      K_AHI:   return K_ALO;
      default: return K_DATA;
    endcase
  endfunction

  // Data bytes travel LSB first, every other byte MSB first
  function automatic logic [7:0] shift_in(kind_t k, logic [7:0] cur, logic bit_in);
    if (k == K_DATA) return {bit_in, cur[7:1]};
    else             return {cur[6:0], bit_in};
  endfunction

endpackage

// File: rtl/cfgslv_line_sync.sv
module cfgslv_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_q;
  logic              sda_q;
  logic              scl_s;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_i;
          sda_pipe <= sda_i;
        end
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
          sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_pipe[LAST];
      sda_q <= sda_pipe[LAST];
    end
  end

  assign scl_s     = scl_pipe[LAST];
  assign sda_lvl   = sda_pipe[LAST];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_lvl;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_lvl;

  // R1: framing events need a high clock, so they never coincide with a clock edge
  a_r1_frame_not_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det || stop_det) |-> !(scl_rise || scl_fall));

endmodule

// File: rtl/cfgslv_regfile.sv
module cfgslv_regfile #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];

  // R5: a written byte is readable at its location on the next cycle
  a_r5_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem[$past(addr)] == $past(wdata)));

endmodule

// File: rtl/cfgslv_byte_engine.sv
module cfgslv_byte_engine
  import cfgslv_pkg::*;
#(
  parameter int         MEM_AW = 6,
  parameter logic [6:0] DEV_ID = 7'h53
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [7:0]        rd_data,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              sda_pull
);

  localparam logic [MEM_AW-1:0] PTR_ONE = MEM_AW'(1);

  phase_t            phase;
  kind_t             kind;
  logic [3:0]        bitcnt;
  logic [7:0]        sh;
  logic [7:0]        tx_sh;
  logic [7:0]        addr_hi;
  logic [MEM_AW-1:0] ptr;
  logic              is_read;

  logic [7:0]        sh_next;
  logic [15:0]       full_addr;
  logic              byte_done;
  logic              dev_hit;

  always_comb begin
    sh_next   = shift_in(kind, sh, sda_lvl);
    full_addr = {addr_hi, sh_next};
    byte_done = (phase == PH_RX) && scl_rise && (bitcnt == 4'd7);
    dev_hit   = (sh_next[7:1] == DEV_ID);
  end

  assign mem_we    = byte_done && (kind == K_DATA);
  assign mem_wdata = sh_next;
  assign mem_addr  = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      kind     <= K_DEV;
      bitcnt   <= '0;
      sh       <= '0;
      tx_sh    <= '0;
      addr_hi  <= '0;
      ptr      <= '0;
      is_read  <= 1'b0;
      sda_pull <= 1'b0;
    end else if (start_det) begin
      phase    <= PH_RX;
      kind     <= K_DEV;
      bitcnt   <= '0;
      sda_pull <= 1'b0;
    end else if (stop_det) begin
      phase    <= PH_IDLE;
      sda_pull <= 1'b0;
    end else begin
      case (phase)
        PH_RX: begin
          if (scl_rise) begin
            sh     <= sh_next;
            bitcnt <= bitcnt + 4'd1;
            if (bitcnt == 4'd7) begin
              bitcnt <= '0;
              phase  <= PH_ACK_PEND;
              case (kind)
                K_DEV: begin
                  is_read <= sh_next[0];
                  if (!dev_hit) phase <= PH_IDLE;
                end
                K_AHI:   addr_hi <= sh_next;
                K_ALO:   ptr     <= full_addr[MEM_AW-1:0];
                default: ptr     <= ptr + PTR_ONE;
              endcase
            end
          end
        end
        PH_ACK_PEND: begin
          if (scl_fall) begin
            sda_pull <= 1'b1;
            phase    <= PH_ACK;
          end
        end
        PH_ACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            kind   <= kind_after(kind);
            if (kind == K_DEV && is_read) begin
              tx_sh    <= rd_data;
              sda_pull <= ~rd_data[0];
              phase    <= PH_TX;
            end else begin
              sda_pull <= 1'b0;
              phase    <= PH_RX;
            end
          end
        end
        PH_TX: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              sda_pull <= 1'b0;
              phase    <= PH_MACK;
            end else begin
              sda_pull <= ~tx_sh[bitcnt[2:0]];
            end
          end
        end
        PH_MACK: begin
          if (scl_rise) begin
            ptr   <= ptr + PTR_ONE;
            phase <= sda_lvl ? PH_IDLE : PH_TXNEXT;
          end
        end
        PH_TXNEXT: begin
          if (scl_fall) begin
            tx_sh    <= rd_data;
            sda_pull <= ~rd_data[0];
            bitcnt   <= '0;
            phase    <= PH_TX;
          end
        end
        default: begin
          sda_pull <= 1'b0;
        end
      endcase
    end
  end

  // R8: drive changes only follow a clock fall or a framing event
  a_r8_drive_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull != $past(sda_pull)) |-> $past(scl_fall || start_det || stop_det));

  // R3: an idle slave never pulls the line
  a_r3_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> !sda_pull);

  // R5: every stored byte advances the pointer by one
  a_r5_ptr_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !start_det && !stop_det) |=> (ptr == $past(ptr) + PTR_ONE));

  // R6: data is only sent in a transaction opened for reading
  a_r6_tx_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_TX) |-> is_read);

  // R1: a start always returns to device byte reception
  a_r1_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (phase == PH_RX && kind == K_DEV && bitcnt == 4'd0));

endmodule

// File: rtl/cfgslv_top.sv
module cfgslv_top #(
  parameter int         MEM_AW      = 6,
  parameter logic [6:0] DEV_ID      = 7'h53,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_pull_o
);

  logic              sda_lvl;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_det;
  logic              stop_det;
  logic              mem_we;
  logic [MEM_AW-1:0] mem_addr;
  logic [7:0]        mem_wdata;
  logic [7:0]        mem_rdata;

  cfgslv_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  cfgslv_byte_engine #(.MEM_AW(MEM_AW), .DEV_ID(DEV_ID)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rd_data   (mem_rdata),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .sda_pull  (sda_pull_o)
  );

  cfgslv_regfile #(.AW(MEM_AW), .DW(8)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mem_we),
    .addr  (mem_addr),
    .wdata (mem_wdata),
    .rdata (mem_rdata)
  );

endmodule

// File: tb/cfgslv_top_bench.sv
module cfgslv_top_bench;

  localparam int CLK_NS = 10;
  localparam int Q      = 8;
  localparam int AW     = 6;
  localparam int DEPTH  = 1 << AW;
  localparam logic [6:0] ID = 7'h53;

  logic clk   = 1'b0;
  logic rst_n = 1'b0;
  logic scl   = 1'b1;
  logic m_low = 1'b0;
  logic sda_pull;
  logic sda_bus;

  assign sda_bus = ~(m_low | sda_pull);

  always #(CLK_NS/2) clk = ~clk;

  cfgslv_top u_cfgslv_top (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl),
    .sda_i      (sda_bus),
    .sda_pull_o (sda_pull)
  );

  int checks = 0;
  int fails  = 0;
  logic [7:0] model [DEPTH];
  int mptr = 0;

  function automatic logic [7:0] dev_byte(logic [6:0] id, logic rw);
    return {id, rw};
  endfunction

  function automatic int ptr_of(logic [7:0] hi, logic [7:0] lo);
    logic [15:0] f;
    f = {hi, lo};
    return int'(f[AW-1:0]);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_low = 1'b0; wq(Q);
    scl   = 1'b1; wq(Q);
    m_low = 1'b1; wq(Q);
    scl   = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; wq(Q);
    scl   = 1'b1; wq(Q);
    m_low = 1'b0; wq(Q);
  endtask

  task automatic clock_bit(input logic b, output logic seen);
    m_low = ~b; wq(Q);
    scl   = 1'b1; wq(Q);
    seen  = sda_bus; wq(Q);
    scl   = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, input logic lsb_first, output logic ack);
    logic s;
    for (int i = 0; i < 8; i++) clock_bit(v[lsb_first ? i : 7 - i], s);
    clock_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic master_ack, output logic [7:0] v);
    logic s;
    for (int i = 0; i < 8; i++) begin
      clock_bit(1'b1, s);
      v[i] = s;
    end
    clock_bit(~master_ack, s);
  endtask

  task automatic set_ptr(input logic [7:0] hi, input logic [7:0] lo, input string req);
    logic a;
    bus_start();
    send_byte(dev_byte(ID, 1'b0), 1'b0, a); chk("R2 write device ack", a, 1'b1);
    send_byte(hi, 1'b0, a);                 chk({req, " high pointer ack"}, a, 1'b1);
    send_byte(lo, 1'b0, a);                 chk({req, " low pointer ack"}, a, 1'b1);
    mptr = ptr_of(hi, lo);
  endtask

  task automatic write_bytes(input int n, input logic [7:0] base, input logic rnd);
    logic a;
    logic [7:0] d;
    for (int i = 0; i < n; i++) begin
      d = rnd ? 8'($urandom) : base + 8'(i * 37);
      send_byte(d, 1'b1, a);
      chk("R5 data ack", a, 1'b1);
      model[mptr] = d;
      mptr = (mptr + 1) % DEPTH;
    end
  endtask

  task automatic read_bytes(input int n, input string req);
    logic a;
    logic [7:0] v;
    bus_start();
    send_byte(dev_byte(ID, 1'b1), 1'b0, a); chk("R2 read device ack", a, 1'b1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, v);
      chk(req, v, model[mptr]);
      mptr = (mptr + 1) % DEPTH;
    end
    wq(Q);
    chk("R7 released after refusal", sda_pull, 1'b0);
    bus_stop();
  endtask

  bit done = 1'b0;

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] v;
    void'($urandom(32'd2718));
    for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;

    wq(4);
    chk("R10 line released in reset", sda_pull, 1'b0);
    rst_n = 1'b1;
    wq(4);
    chk("R10 line released after reset", sda_pull, 1'b0);

    // R10: memory starts at zero, pointer at 0
    read_bytes(1, "R10 reset memory at pointer 0");

    // R4/R5: pointer 0, two bytes LSB first
    set_ptr(8'h00, 8'h00, "R4");
    send_byte(8'h3C, 1'b1, a); chk("R5 data ack", a, 1'b1);
    send_byte(8'hA1, 1'b1, a); chk("R5 data ack", a, 1'b1);
    model[0] = 8'h3C; model[1] = 8'hA1; mptr = 2;
    bus_stop();

    // R4/R6/R9: random read from pointer 0x0001 through a repeated start
    set_ptr(8'h00, 8'h01, "R4");
    bus_start();
    send_byte(dev_byte(ID, 1'b1), 1'b0, a); chk("R2 read device ack", a, 1'b1);
    recv_byte(1'b0, v);
    chk("R6 LSB-first data from pointer 1 (R4 MSB-first pointer)", v, 8'hA1);
    mptr = 2;
    wq(Q);
    chk("R7 released after refusal", sda_pull, 1'b0);
    bus_stop();

    // R9/R7: pointer survives, sequential read with master acks
    set_ptr(8'h00, 8'h00, "R9");
    bus_stop();
    read_bytes(2, "R9 R7 sequential read from kept pointer");

    // R5: pointer wraps from last location to 0
    set_ptr(8'h00, 8'(DEPTH - 1), "R5");
    write_bytes(3, 8'h5A, 1'b0);
    bus_stop();
    set_ptr(8'h00, 8'(DEPTH - 1), "R5");
    read_bytes(3, "R5 wrap readback");

    // R3: one-bit identity mismatch, then bytes that must be ignored
    bus_start();
    send_byte(dev_byte(ID ^ 7'h01, 1'b0), 1'b0, a); chk("R3 no ack on mismatch", a, 1'b0);
    send_byte(8'h00, 1'b0, a); chk("R3 ignored byte not acked", a, 1'b0);
    send_byte(8'h05, 1'b0, a); chk("R3 ignored byte not acked", a, 1'b0);
    send_byte(8'hFF, 1'b1, a); chk("R3 ignored byte not acked", a, 1'b0);
    bus_stop();
    set_ptr(8'h00, 8'h05, "R3");
    read_bytes(1, "R3 location 5 untouched");

    // R1: start in the middle of a data byte leaves no partial write
    set_ptr(8'h00, 8'h0A, "R1");
    for (int i = 0; i < 3; i++) clock_bit(1'b0, a);
    bus_start();
    send_byte(dev_byte(ID, 1'b1), 1'b0, a); chk("R1 device byte after mid-byte start", a, 1'b1);
    recv_byte(1'b0, v);
    chk("R1 no partial write at 0x0A", v, model[8'h0A]);
    mptr = 8'h0B;
    bus_stop();

    // R8: line is released while the bus sits idle
    wq(4 * Q);
    chk("R8 idle line released", sda_pull, 1'b0);

    // Random transactions; high pointer byte bits above AW are dropped (R4)
    for (int t = 0; t < 14; t++) begin
      logic [7:0] hi;
      logic [7:0] lo;
      int n;
      hi = 8'($urandom);
      lo = 8'($urandom);
      n  = 1 + int'($urandom % 3);
      set_ptr(hi, lo, "R4");
      write_bytes(n, 8'h00, 1'b1);
      bus_stop();
      set_ptr(8'($urandom), lo, "R4");
      read_bytes(n, "R5 R6 random readback");
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule